// File: doc/BRIEF.md
# Signed Iterative Hardware Divider

This block divides a 32-bit two's-complement dividend by a 16-bit two's-complement divisor and returns a 32-bit quotient and a remainder that is computed in 16 bits and sign-extended to 32. It sits on a simple register bus with one write port and one read port, both selected by a 2-bit register address. Software first stores the dividend. It then stores the divisor, and that write alone starts the operation.

The operation always takes a fixed number of clocks, which is six by default. Internally, several quotient bits are retired per clock on unsigned magnitudes. A last clock applies the signs and registers the result. A read of the quotient or remainder that arrives while the operation is still running is held off with a wait signal until the result is valid, so software never sees a stale value. A zero divisor raises a warning flag and produces fixed, defined results.

Top module: `sdiv_unit`

## Requirements
- R1: After reset, the quotient and remainder registers read as zero, `busy` is low and `div_zero` is low.
- R2: Register addresses are 0 = dividend, 1 = divisor, 2 = quotient, 3 = remainder. A write to address 0 stores all 32 bits of `wdata`. A write to address 1 stores `wdata[15:0]`, and reading address 1 returns that value sign-extended to 32 bits.
- R3: A write to address 1 starts a division. `busy` is high for exactly 6 clocks after that write edge, and the new quotient and remainder are readable from the 6th rising edge after the write edge onward.
- R4: For a nonzero divisor, the quotient is the exact quotient truncated toward zero, taken modulo 2^32 (so -2^31 / -1 gives 0x80000000). The remainder is dividend minus quotient times divisor: it has the sign of the dividend and a magnitude below that of the divisor.
- R5: The remainder register holds a 16-bit result sign-extended to 32 bits.
- R6: A read of address 2 or 3 while `busy` is high drives `ready` low until the result is valid. Reads of addresses 0 and 1, and any read while not busy, return with `ready` high in the same cycle.
- R7: A divisor of zero sets `div_zero` at the write edge, and the division then yields a quotient of 0xFFFFFFFF and a remainder equal to the dividend's low 16 bits sign-extended. The flag stays set until the next write of a nonzero divisor clears it.
- R8: A divisor write while `busy` is high abandons the running division and starts over with the stored dividend and the new divisor. The full latency counts again from the new write.
- R9: A dividend write while `busy` is high does not change the running division; it only affects the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address (0 dividend, 1 divisor, 2 quotient, 3 remainder) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while `ready` is high |
| ready | output | 1 | Low while a result read must wait |
| busy | output | 1 | Division in progress |
| div_zero | output | 1 | Divide-by-zero warning flag |

## Verification
The divisor write edge starts the count. `busy` and `div_zero` change right after that edge, and the quotient and remainder registers update on the 6th rising edge after it. The bench drives and samples only in the low clock phase. It issues a quotient read in the first low phase after the write edge and expects exactly six samples with `ready` low before the data. A restart shifts that window to count from the last divisor write, and a late dividend write shortens the remaining wait without changing the result. Expected values come from 64-bit integer division in the bench, over a sweep of dividends against divisors that include 0, ±1 and both 16-bit extremes.

// File: rtl/hdiv_pkg.sv
`timescale 1ns/1ps
package hdiv_pkg;
  // Register map seen on the bus; the address decode depends on these codes.
  typedef enum logic [1:0] {
    REG_DVD = 2'd0,
    REG_DSR = 2'd1,
    REG_QUO = 2'd2,
    REG_REM = 2'd3
  } hdiv_reg_e;

  // Ceiling division for elaboration-time sizing.
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/hdiv_seq.sv
`timescale 1ns/1ps
// Step sequencer: ITER iteration cycles followed by one finishing cycle.
module hdiv_seq #(
  parameter int ITER = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic step,
  output logic fin
);
  localparam int CW = $clog2(ITER + 1);
  localparam logic [CW-1:0] LAST = CW'(ITER);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign step = busy_q && (cnt_q != LAST);
  assign fin  = busy_q && (cnt_q == LAST);

  // R3: a start always leaves the sequencer busy on the next cycle
  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R3: the finishing cycle is never followed by busy unless restarted
  assert_fin_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !start) |=> !busy);
endmodule

// File: rtl/hdiv_core.sv
`timescale 1ns/1ps
// Unsigned magnitude datapath: restoring division, BPS bits per step.
module hdiv_core #(
  parameter int DW   = 32,
  parameter int DSW  = 16,
  parameter int ITER = 5,
  parameter int BPS  = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic           fin,
  input  logic [DW-1:0]  dvd_mag,
  input  logic [DSW-1:0] dsr_mag,
  output logic [DW-1:0]  q_mag,
  output logic [DSW-1:0] r_mag
);
  localparam int PAD_W = ITER * BPS;
  localparam int REM_W = DSW + 1;

  typedef struct packed {
    logic [REM_W-1:0] rem;
    logic [PAD_W-1:0] shq;
  } part_t;

  part_t           st_q, st_d;
  logic [DSW-1:0]  dsr_q;

  // One step: BPS shift-compare-subtract rounds, most significant bit first.
  function automatic part_t radix_step(input part_t cur, input logic [DSW-1:0] d);
    part_t w;
    w = cur;
    for (int i = 0; i < BPS; i++) begin
      w.rem = {w.rem[REM_W-2:0], w.shq[PAD_W-1]};
      if (w.rem >= {1'b0, d}) begin
        w.rem = w.rem - {1'b0, d};
        w.shq = {w.shq[PAD_W-2:0], 1'b1};
      end else begin
        w.shq = {w.shq[PAD_W-2:0], 1'b0};
      end
    end
    return w;
  endfunction

  always_comb st_d = radix_step(st_q, dsr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      dsr_q <= '0;
    end else if (load) begin
      st_q.rem <= '0;
      st_q.shq <= PAD_W'(dvd_mag);
      dsr_q    <= dsr_mag;
    end else if (step) begin
      st_q <= st_d;
    end
  end

  assign q_mag = st_q.shq[DW-1:0];
  assign r_mag = st_q.rem[DSW-1:0];

  // R4: the partial remainder stays below the divisor magnitude
  assert_rem_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((step || fin) && dsr_q != '0) |-> (st_q.rem < {1'b0, dsr_q}));

  generate
    if (PAD_W > DW) begin : g_pad
      // R4: quotient bits of the zero padding are zero when finishing
      assert_pad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && dsr_q != '0) |-> (st_q.shq[PAD_W-1:DW] == '0));
    end
  endgenerate
endmodule

// File: rtl/hdiv_signfix.sv
`timescale 1ns/1ps
// Final sign correction and divide-by-zero substitution.
module hdiv_signfix #(
  parameter int DW  = 32,
  parameter int DSW = 16
) (
  input  logic [DW-1:0]  q_mag,
  input  logic [DSW-1:0] r_mag,
  input  logic           neg_q,
  input  logic           neg_r,
  input  logic           zero,
  input  logic [DSW-1:0] dvd_lo,
  output logic [DW-1:0]  quot,
  output logic [DW-1:0]  rem
);
  function automatic logic [DW-1:0] sext(input logic [DSW-1:0] v);
    return {{(DW-DSW){v[DSW-1]}}, v};
  endfunction

  function automatic logic [DW-1:0] apply_q(input logic [DW-1:0] m, input logic n);
    return n ? (~m + 1'b1) : m;
  endfunction

  function automatic logic [DSW-1:0] apply_r(input logic [DSW-1:0] m, input logic n);
    return n ? (~m + 1'b1) : m;
  endfunction

  always_comb begin
    if (zero) begin
      quot = '1;
      rem  = sext(dvd_lo);
    end else begin
      quot = apply_q(q_mag, neg_q);
      rem  = sext(apply_r(r_mag, neg_r));
    end
  end
endmodule

// File: rtl/sdiv_unit.sv
`timescale 1ns/1ps
module sdiv_unit #(
  parameter int DW      = 32,
  parameter int DSW     = 16,
  parameter int LATENCY = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          ready,
  output logic          busy,
  output logic          div_zero
);
  import hdiv_pkg::*;

  localparam int ITER = LATENCY - 1;
  localparam int BPS  = ceil_div(DW, ITER);
  localparam int CW   = $clog2(ITER + 1);

  hdiv_reg_e reg_sel;
  assign reg_sel = hdiv_reg_e'(addr);

  logic [DW-1:0]  dvd_q, quot_q, rem_q;
  logic [DSW-1:0] dsr_q;
  logic           zflag_q;
  logic           op_neg_q, op_neg_r, op_zero;
  logic [DSW-1:0] op_lo;

  // Named internal events
  logic start, step, fin, commit;
  assign start  = wr_en && (reg_sel == REG_DSR);
  assign commit = fin && !start;

  function automatic logic [DW-1:0] mag_dw(input logic [DW-1:0] v);
    return v[DW-1] ? (~v + 1'b1) : v;
  endfunction
  function automatic logic [DSW-1:0] mag_dsw(input logic [DSW-1:0] v);
    return v[DSW-1] ? (~v + 1'b1) : v;
  endfunction

  logic [DSW-1:0] new_dsr;
  assign new_dsr = wdata[DSW-1:0];

  hdiv_seq #(.ITER(ITER)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .step(step), .fin(fin)
  );

  logic [DW-1:0]  q_mag;
  logic [DSW-1:0] r_mag;

  hdiv_core #(.DW(DW), .DSW(DSW), .ITER(ITER), .BPS(BPS)) u_core (
    .clk(clk), .rst_n(rst_n), .load(start), .step(step), .fin(fin),
    .dvd_mag(mag_dw(dvd_q)), .dsr_mag(mag_dsw(new_dsr)),
    .q_mag(q_mag), .r_mag(r_mag)
  );

  logic [DW-1:0] fix_q, fix_r;

  hdiv_signfix #(.DW(DW), .DSW(DSW)) u_fix (
    .q_mag(q_mag), .r_mag(r_mag), .neg_q(op_neg_q), .neg_r(op_neg_r),
    .zero(op_zero), .dvd_lo(op_lo), .quot(fix_q), .rem(fix_r)
  );

  // Operand registers and per-operation snapshot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q    <= '0;
      dsr_q    <= '0;
      zflag_q  <= 1'b0;
      op_neg_q <= 1'b0;
      op_neg_r <= 1'b0;
      op_zero  <= 1'b0;
      op_lo    <= '0;
    end else if (wr_en) begin
      if (reg_sel == REG_DVD) begin
        dvd_q <= wdata;
      end else if (reg_sel == REG_DSR) begin
        dsr_q    <= new_dsr;
        zflag_q  <= (new_dsr == '0);
        op_zero  <= (new_dsr == '0);
        op_neg_q <= dvd_q[DW-1] ^ new_dsr[DSW-1];
        op_neg_r <= dvd_q[DW-1];
        op_lo    <= dvd_q[DSW-1:0];
      end
    end
  end

  // Result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quot_q <= '0;
      rem_q  <= '0;
    end else if (commit) begin
      quot_q <= fix_q;
      rem_q  <= fix_r;
    end
  end

  // Read side with wait insertion on result reads
  always_comb begin
    unique case (reg_sel)
      REG_DVD: rdata = dvd_q;
      REG_DSR: rdata = {{(DW-DSW){dsr_q[DSW-1]}}, dsr_q};
      REG_QUO: rdata = quot_q;
      default: rdata = rem_q;
    endcase
  end

  assign ready    = !(rd_en && addr[1] && busy);
  assign div_zero = zflag_q;

  // Independent latency tracker for the latency assertion
  logic [CW-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               lat_q <= '0;
    else if (start)                           lat_q <= '0;
    else if (busy && lat_q != CW'(ITER))      lat_q <= lat_q + 1'b1;
  end

  // R3: the finishing cycle falls LATENCY-1 cycles after the start edge
  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (lat_q == CW'(ITER)));
  // R6: results never move while a division is still iterating
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin) |=> ($stable(quot_q) && $stable(rem_q)));
  // R7: a zero divisor yields the all-ones quotient with the flag up
  assert_zero_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && op_zero) |=> (quot_q == '1 && zflag_q));
  // R4: a committed remainder is zero or carries the dividend's sign
  assert_rem_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !op_zero) |=> (rem_q == '0 || rem_q[DW-1] == $past(op_neg_r)));
  // R5: remainder upper bits are a sign extension of bit DSW-1
  assert_rem_sext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (rem_q[DW-1:DSW-1] == '0 || rem_q[DW-1:DSW-1] == '1));
endmodule

// File: tb/test_sdiv_unit.sv
`timescale 1ns/1ps
module test_sdiv_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ready, busy, div_zero;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam int LAT = 6;

  always #2.5 clk = ~clk;

  sdiv_unit i_sdiv_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ready(ready), .busy(busy), .div_zero(div_zero)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; leaves at the next falling edge.
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Called at a falling edge; counts low-phase samples with ready low.
  task automatic rd(input logic [1:0] a, output logic [31:0] d, output int waits);
    rd_en = 1'b1; addr = a; waits = 0;
    #1;
    while (!ready && waits < 50) begin
      waits++;
      @(negedge clk); #1;
    end
    d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic void model(input logic [31:0] a, input logic [15:0] b,
                                output logic [31:0] q, output logic [31:0] r);
    longint sa, sb, lq, lr;
    if (b == 16'd0) begin
      q = 32'hFFFF_FFFF;
      r = {{16{a[15]}}, a[15:0]};
    end else begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      lq = sa / sb;
      lr = sa % sb;
      q = lq[31:0];
      r = lr[31:0];
    end
  endfunction

  logic [31:0] dvds [12] = '{32'd0, 32'd1, 32'd1000, 32'hFFFF_FC18, 32'd12345678,
                             32'hFF43_9EB2, 32'h7FFF_FFFF, 32'h8000_0000, 32'd32767,
                             32'hFFFF_8000, 32'd7, 32'hFFFF_FFF9};
  logic [15:0] dsrs [10] = '{16'd0, 16'd1, 16'hFFFF, 16'd7, 16'hFFFD, 16'd32767,
                             16'h8000, 16'd100, 16'hFC18, 16'd2};

  initial begin
    logic [31:0] d, eq, er;
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 div_zero", {31'd0, div_zero}, 32'd0);
    rd(2'd2, d, w); chk("R1 quotient", d, 32'd0); chk("R1 quotient wait", w, 0);
    rd(2'd3, d, w); chk("R1 remainder", d, 32'd0);

    // Sweep: R3 latency, R4 values, R5 extension, R7 zero flag
    for (int i = 0; i < 12; i++) begin
      for (int j = 0; j < 10; j++) begin
        model(dvds[i], dsrs[j], eq, er);
        wr(2'd0, dvds[i]);
        wr(2'd1, {16'hA5A5, dsrs[j]});
        chk("R3 busy after start", {31'd0, busy}, 32'd1);
        chk("R7 flag", {31'd0, div_zero}, {31'd0, dsrs[j] == 16'd0});
        rd(2'd2, d, w);
        chk("R3 R6 quotient stall", w, LAT);
        chk((dsrs[j] == 0) ? "R7 quotient" : "R4 quotient", d, eq);
        rd(2'd3, d, w);
        chk((dsrs[j] == 0) ? "R7 remainder" : "R4 R5 remainder", d, er);
        chk("R3 idle after result", {31'd0, busy}, 32'd0);
      end
    end

    // R2: readback of operands, divisor sign-extended
    wr(2'd0, 32'd1000);
    wr(2'd1, 32'h1234_FFF7);
    rd(2'd1, d, w);
    chk("R2 divisor readback", d, 32'hFFFF_FFF7);
    chk("R6 operand read no wait", w, 0);
    rd(2'd0, d, w);
    chk("R2 dividend readback", d, 32'd1000);
    repeat (LAT) @(negedge clk);

    // R8: restart by a second divisor write one cycle later
    wr(2'd0, 32'd1000);
    wr(2'd1, 32'd7);
    wr(2'd1, 32'hFFF7);
    rd(2'd2, d, w);
    chk("R8 restart stall", w, LAT);
    chk("R8 quotient", d, 32'hFFFF_FF91);
    rd(2'd3, d, w);
    chk("R8 remainder", d, 32'd1);

    // R9: dividend write during busy does not disturb the running divide
    wr(2'd0, 32'hFFFF_EC78);
    wr(2'd1, 32'd13);
    wr(2'd0, 32'd77);
    rd(2'd2, d, w);
    chk("R9 stall", w, LAT - 1);
    chk("R9 quotient", d, 32'hFFFF_FE80);
    rd(2'd3, d, w);
    chk("R9 remainder", d, 32'hFFFF_FFF8);
    rd(2'd0, d, w);
    chk("R9 new dividend held", d, 32'd77);

    // R7: flag clears only on next nonzero divisor
    wr(2'd1, 32'd0);
    repeat (LAT) @(negedge clk);
    chk("R7 flag stays", {31'd0, div_zero}, 32'd1);
    wr(2'd1, 32'd5);
    chk("R7 flag cleared", {31'd0, div_zero}, 32'd0);
    rd(2'd2, d, w);
    chk("R7 next quotient", d, 32'd15);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule